// File: doc/BRIEF.md
# Sector-at-a-Time PIO Disk Transfer Sequencer

This block sits on the host side of a parallel disk taskfile and moves a run of 512-byte sectors between a pair of word streams and the drive. It issues one command per sector and programs the address registers for every sector. When any address bit above bit 27 of the starting block is set, it uses the extended 48-bit addressing form, which writes the upper address bytes in a separate pass first. Around each data phase it runs the busy/data-request status handshake, and it stops at the first failure. It then reports how many sectors finished.

A request is a one-cycle start strobe with a direction bit, a 48-bit starting block and a sector count. On the read path the sequencer first asks the drive for its power state. If the drive reports standby, the first sector is allowed a longer wait so the drive can spin up. Register traffic uses a simple request/acknowledge port: one access is outstanding at a time, and it carries a 3-bit taskfile address. The drive's status byte uses bit 7 for busy (BSY), bit 3 for data request (DRQ) and bit 0 for error (ERR).

Top module: `ata_pio_seq`

## Requirements
- R1: A start with a sector count of 0 raises `done` on the next cycle with `done_cnt` 0, and no register access is made.
- R2: The extended (48-bit) form is used exactly when bits 47..28 of the starting block are not all zero. The form is chosen once per request.
- R3: In the extended form each sector is programmed in this order: sector count (address 2) = 0, address 3 = block bits 31..24, address 4 = bits 39..32, address 5 = bits 47..40. Then come the R4 low pass, the device register (address 6) = 0x40 with bit 4 = drive number, and the command (address 7): 0x24 for a read, 0x34 for a write.
- R4: The low pass writes address 2 = 1, address 3 = bits 7..0, address 4 = bits 15..8 and address 5 = bits 23..16. In the 28-bit form the device register then gets 0x40, with bit 4 = drive number and bits 3..0 = block bits 27..24, and the command is 0x20 for a read or 0x30 for a write.
- R5: Each command moves exactly 256 words through the data register (address 0). Write words are taken in stream order from `wr_data`, and read words appear in order on `rd_data` with `rd_valid`.
- R6: After each sector's data, the status register (address 7) is read once. The block address and the completed count then advance by one.
- R7: Before each sector is programmed, status is polled until BSY is clear. If BSY is still set when the normal wait limit runs out, the request ends with the count reached so far and no further command is issued.
- R8: After the command and a settle delay, status is polled until BSY clears. The status masked with 0x89 must then equal 0x08, or the request ends with the count completed so far.
- R9: A read request first selects the drive and writes 0xE5 to address 7, then polls status. If ERR is clear, it reads address 2. A value of 0 there means standby, and the first sector's post-command wait then uses the longer spin-up limit instead of the normal one.
- R10: `done` is a single-cycle pulse, `done_cnt` never exceeds the requested count, and a start while a request is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| dir_wr | input | 1 | 1 = write to drive, 0 = read from drive |
| lba_in | input | LBA_W | Starting block address |
| count_in | input | CNT_W | Number of sectors |
| reg_req | output | 1 | Register access request, held until acknowledged |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | 3 | Taskfile register address |
| reg_wdata | output | DATA_W | Write data |
| reg_ack | input | 1 | Access complete |
| reg_rdata | input | DATA_W | Read data, valid with `reg_ack` |
| wr_valid | input | 1 | Write-stream word available |
| wr_data | input | DATA_W | Write-stream word |
| wr_ready | output | 1 | Write-stream word taken when high with `wr_valid` |
| rd_valid | output | 1 | Read-stream word valid (one cycle) |
| rd_data | output | DATA_W | Read-stream word |
| done | output | 1 | Request finished (one cycle) |
| done_cnt | output | CNT_W | Sectors completed, valid with `done` |

## Verification
The transfer path is tried with a two-sector 28-bit write, a one-sector 48-bit read, and single writes at 0x0FFFFFFF and 0x10000000. Together they separate the two address forms, show the order of the high and low passes, and show the device nibble and the address increment between sectors. Failure patterns are a drive that never drops BSY, an ERR that appears on a later sector, and a missing DRQ; these show that the sequencer stops at the right sector and reports the count it reached. The same slow-to-ready read is run once with a standby answer and once with an active answer to the power query, which shows whether the spin-up limit is applied.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

   localparam logic [2:0] RA_DATA  = 3'd0;
   localparam logic [2:0] RA_SCNT  = 3'd2;
   localparam logic [2:0] RA_LLO   = 3'd3;
   localparam logic [2:0] RA_LMID  = 3'd4;
   localparam logic [2:0] RA_LHI   = 3'd5;
   localparam logic [2:0] RA_DEV   = 3'd6;
   localparam logic [2:0] RA_CMDST = 3'd7;

   localparam logic [7:0] OP_RD    = 8'h20;
   localparam logic [7:0] OP_RDX   = 8'h24;
   localparam logic [7:0] OP_WR    = 8'h30;
   localparam logic [7:0] OP_WRX   = 8'h34;
   localparam logic [7:0] OP_PWR   = 8'hE5;

   localparam logic [7:0] SB_MASK  = 8'h89;
   localparam logic [7:0] SB_XFER  = 8'h08;

   localparam logic [3:0] TF_HI_FIRST = 4'd0;
   localparam logic [3:0] TF_LO_FIRST = 4'd4;
   localparam logic [3:0] TF_LAST     = 4'd9;

   typedef enum logic [3:0] {
      ST_IDLE, ST_SEL, ST_PW_POLL0, ST_PW_CMD, ST_PW_SETTLE, ST_PW_POLL,
      ST_PW_SC, ST_PRE_POLL, ST_TF, ST_SETTLE, ST_POST_POLL, ST_DATA,
      ST_CLR, ST_NEXT, ST_FIN
   } seq_state_e;

   function automatic logic [7:0] dev_base(input bit drv);
      return 8'h40 | (drv ? 8'h10 : 8'h00);
   endfunction

endpackage

// File: rtl/ata_wait_timer.sv
module ata_wait_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr)           cnt_q <= '0;
      else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q >= limit);
endmodule

// File: rtl/ata_tf_planner.sv
module ata_tf_planner
   import ata_pio_pkg::*;
#(
   parameter int LBA_W  = 48,
   parameter int DATA_W = 16,
   parameter bit DRIVE  = 1'b0
) (
   input  logic [LBA_W-1:0]  lba,
   input  logic              m48,
   input  logic              dir_w,
   input  logic [3:0]        step,
   output logic [2:0]        addr,
   output logic [DATA_W-1:0] data
);
   logic [7:0] byte_v;

   generate
      if (LBA_W != 48) begin : g_bad_lba
         $error("ata_tf_planner: LBA_W must be 48");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("ata_tf_planner: DATA_W must be at least 8");
      end
   endgenerate

   always_comb begin
      addr   = RA_DATA;
      byte_v = 8'h00;
      case (step)
         4'd0: begin addr = RA_SCNT; byte_v = 8'h00;        end
         4'd1: begin addr = RA_LLO;  byte_v = lba[31:24];   end
         4'd2: begin addr = RA_LMID; byte_v = lba[39:32];   end
         4'd3: begin addr = RA_LHI;  byte_v = lba[47:40];   end
         4'd4: begin addr = RA_SCNT; byte_v = 8'h01;        end
         4'd5: begin addr = RA_LLO;  byte_v = lba[7:0];     end
         4'd6: begin addr = RA_LMID; byte_v = lba[15:8];    end
         4'd7: begin addr = RA_LHI;  byte_v = lba[23:16];   end
         4'd8: begin
            addr   = RA_DEV;
            byte_v = dev_base(DRIVE) | (m48 ? 8'h00 : {4'h0, lba[27:24]});
         end
         4'd9: begin
            addr   = RA_CMDST;
            byte_v = dir_w ? (m48 ? OP_WRX : OP_WR) : (m48 ? OP_RDX : OP_RD);
         end
         default: begin addr = RA_DATA; byte_v = 8'h00; end
      endcase
   end

   assign data = {{(DATA_W-8){1'b0}}, byte_v};
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
   import ata_pio_pkg::*;
#(
   parameter int LBA_W         = 48,
   parameter int CNT_W         = 16,
   parameter int DATA_W        = 16,
   parameter int SECTOR_WORDS  = 256,
   parameter int TMO_CYCLES    = 100_000_000,
   parameter int SPIN_CYCLES   = 250_000_000,
   parameter int SETTLE_CYCLES = 2500,
   parameter bit DRIVE         = 1'b0,
   parameter bit PWR_PROBE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dir_wr,
   input  logic [LBA_W-1:0]  lba_in,
   input  logic [CNT_W-1:0]  count_in,
   output logic              reg_req,
   output logic              reg_we,
   output logic [2:0]        reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_ack,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic [CNT_W-1:0]  done_cnt
);
   localparam int MAX_A  = (TMO_CYCLES > SPIN_CYCLES) ? TMO_CYCLES : SPIN_CYCLES;
   localparam int MAX_L  = (MAX_A > SETTLE_CYCLES) ? MAX_A : SETTLE_CYCLES;
   localparam int TMR_W  = $clog2(MAX_L + 2);
   localparam int WC_W   = $clog2(SECTOR_WORDS + 1);
   localparam logic [WC_W-1:0] WC_LAST = WC_W'(SECTOR_WORDS - 1);

   generate
      if (SECTOR_WORDS < 1) begin : g_bad_words
         $error("ata_pio_seq: SECTOR_WORDS must be positive");
      end
      if (TMO_CYCLES < 1 || SPIN_CYCLES < TMO_CYCLES) begin : g_bad_tmo
         $error("ata_pio_seq: spin-up limit must not be below the normal limit");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("ata_pio_seq: CNT_W must be positive");
      end
   endgenerate

   seq_state_e st, st_nx;

   logic [LBA_W-1:0]  lba_q;
   logic [CNT_W-1:0]  left_q, done_q, req_cnt_q;
   logic              dir_q, m48_q, spin_q;
   logic [3:0]        step_q;
   logic [WC_W-1:0]   wcnt_q;
   logic              idle_w;

   logic [2:0]        acc_addr, tf_addr;
   logic              acc_we, acc_st, issue, acc_done;
   logic [DATA_W-1:0] acc_wdata, tf_data;
   logic [7:0]        sb;
   logic              tmr_clr, tmr_exp;
   logic [TMR_W-1:0]  tmr_lim;

   ata_tf_planner #(.LBA_W(LBA_W), .DATA_W(DATA_W), .DRIVE(DRIVE)) u_plan (
      .lba(lba_q), .m48(m48_q), .dir_w(dir_q), .step(step_q),
      .addr(tf_addr), .data(tf_data)
   );

   ata_wait_timer #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(tmr_lim), .expired(tmr_exp)
   );

   assign idle_w   = (st == ST_IDLE);
   assign sb       = reg_rdata[7:0];
   assign acc_done = reg_req && reg_ack;
   assign tmr_clr  = (st_nx != st);
   assign wr_ready = (st == ST_DATA) && dir_q && !reg_req;
   assign done     = (st == ST_FIN);
   assign done_cnt = done_q;

   // Access selection per state
   always_comb begin
      acc_st    = 1'b1;
      acc_addr  = RA_CMDST;
      acc_we    = 1'b0;
      acc_wdata = '0;
      case (st)
         ST_SEL: begin
            acc_addr  = RA_DEV;
            acc_we    = 1'b1;
            acc_wdata = {{(DATA_W-8){1'b0}}, dev_base(DRIVE)};
         end
         ST_PW_CMD: begin
            acc_we    = 1'b1;
            acc_wdata = {{(DATA_W-8){1'b0}}, OP_PWR};
         end
         ST_PW_SC: acc_addr = RA_SCNT;
         ST_TF: begin
            acc_addr  = tf_addr;
            acc_we    = 1'b1;
            acc_wdata = tf_data;
         end
         ST_DATA: begin
            acc_addr = RA_DATA;
            acc_we   = dir_q;
         end
         ST_PW_POLL0, ST_PW_POLL, ST_PRE_POLL, ST_POST_POLL, ST_CLR: ;
         default: acc_st = 1'b0;
      endcase
   end

   assign issue = acc_st && !reg_req && (!(st == ST_DATA && dir_q) || wr_valid);

   always_comb begin
      case (st)
         ST_SETTLE, ST_PW_SETTLE: tmr_lim = TMR_W'(SETTLE_CYCLES);
         ST_POST_POLL:            tmr_lim = spin_q ? TMR_W'(SPIN_CYCLES) : TMR_W'(TMO_CYCLES);
         default:                 tmr_lim = TMR_W'(TMO_CYCLES);
      endcase
   end

   // Next state
   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE:
            if (start) st_nx = (count_in == '0) ? ST_FIN : ST_SEL;
         ST_SEL:
            if (acc_done) st_nx = (dir_q || !PWR_PROBE) ? ST_PRE_POLL : ST_PW_POLL0;
         ST_PW_POLL0:
            if (acc_done) begin
               if (!sb[7])       st_nx = ST_PW_CMD;
               else if (tmr_exp) st_nx = ST_FIN;
            end
         ST_PW_CMD:
            if (acc_done) st_nx = ST_PW_SETTLE;
         ST_PW_SETTLE:
            if (tmr_exp) st_nx = ST_PW_POLL;
         ST_PW_POLL:
            if (acc_done) begin
               if (!sb[7])       st_nx = sb[0] ? ST_PRE_POLL : ST_PW_SC;
               else if (tmr_exp) st_nx = ST_FIN;
            end
         ST_PW_SC:
            if (acc_done) st_nx = ST_PRE_POLL;
         ST_PRE_POLL:
            if (acc_done) begin
               if (!sb[7])       st_nx = ST_TF;
               else if (tmr_exp) st_nx = ST_FIN;
            end
         ST_TF:
            if (acc_done && step_q == TF_LAST) st_nx = ST_SETTLE;
         ST_SETTLE:
            if (tmr_exp) st_nx = ST_POST_POLL;
         ST_POST_POLL:
            if (acc_done) begin
               if (!sb[7])       st_nx = ((sb & SB_MASK) == SB_XFER) ? ST_DATA : ST_FIN;
               else if (tmr_exp) st_nx = ST_FIN;
            end
         ST_DATA:
            if (acc_done && wcnt_q == WC_LAST) st_nx = ST_CLR;
         ST_CLR:
            if (acc_done) st_nx = ST_NEXT;
         ST_NEXT:
            st_nx = (left_q == CNT_W'(1)) ? ST_FIN : ST_PRE_POLL;
         ST_FIN:
            st_nx = ST_IDLE;
         default:
            st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         lba_q     <= '0;
         left_q    <= '0;
         done_q    <= '0;
         req_cnt_q <= '0;
         dir_q     <= 1'b0;
         m48_q     <= 1'b0;
         spin_q    <= 1'b0;
         step_q    <= '0;
         wcnt_q    <= '0;
         reg_req   <= 1'b0;
         reg_we    <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
      end else begin
         st <= st_nx;

         if (issue) begin
            reg_req   <= 1'b1;
            reg_addr  <= acc_addr;
            reg_we    <= acc_we;
            reg_wdata <= (st == ST_DATA && dir_q) ? wr_data : acc_wdata;
         end else if (acc_done) begin
            reg_req <= 1'b0;
         end

         rd_valid <= acc_done && (st == ST_DATA) && !dir_q;
         if (acc_done && (st == ST_DATA) && !dir_q) rd_data <= reg_rdata;

         if (idle_w && start) begin
            lba_q     <= lba_in;
            left_q    <= count_in;
            req_cnt_q <= count_in;
            done_q    <= '0;
            dir_q     <= dir_wr;
            m48_q     <= |lba_in[LBA_W-1:28];
            spin_q    <= 1'b0;
         end

         if (st == ST_PW_SC && acc_done) spin_q <= (sb == 8'h00);
         if (st == ST_POST_POLL && st_nx != ST_POST_POLL) spin_q <= 1'b0;

         if (st == ST_PRE_POLL && st_nx == ST_TF) step_q <= m48_q ? TF_HI_FIRST : TF_LO_FIRST;
         else if (st == ST_TF && acc_done)        step_q <= step_q + 1'b1;

         if (st == ST_POST_POLL && st_nx == ST_DATA) wcnt_q <= '0;
         else if (st == ST_DATA && acc_done)         wcnt_q <= wcnt_q + 1'b1;

         if (st == ST_NEXT) begin
            done_q <= done_q + 1'b1;
            lba_q  <= lba_q + 1'b1;
            left_q <= left_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CNT_W-1:0]  count_in,
   input logic              idle,
   input logic              reg_req,
   input logic              reg_ack,
   input logic              reg_we,
   input logic [2:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              wr_ready,
   input logic              rd_valid,
   input logic              done,
   input logic [CNT_W-1:0]  done_cnt,
   input logic [CNT_W-1:0]  req_cnt
);
   a_r1_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (start && idle && count_in == '0) |=> (done && done_cnt == '0 && !reg_req));

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_cnt <= req_cnt));

   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

   a_r5_rd_origin: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(reg_req && reg_ack && !reg_we && reg_addr == 3'd0));

   a_r5_wr_take: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> !reg_req);
endmodule

bind ata_pio_seq ata_pio_seq_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .count_in(count_in), .idle(idle_w),
   .reg_req(reg_req), .reg_ack(reg_ack), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .wr_ready(wr_ready), .rd_valid(rd_valid),
   .done(done), .done_cnt(done_cnt), .req_cnt(req_cnt_q)
);

// File: tb/ata_pio_seq_tb.sv
`timescale 1ns/1ps
module ata_pio_seq_tb_top;
   localparam int CNT_W = 16;
   localparam int DW    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, dir_wr = 1'b0;
   logic [47:0] lba_in = '0;
   logic [CNT_W-1:0] count_in = '0;
   logic reg_req, reg_we, reg_ack = 1'b0;
   logic [2:0] reg_addr;
   logic [DW-1:0] reg_wdata, reg_rdata = '0;
   logic wr_valid = 1'b1;
   logic [DW-1:0] wr_data = 16'hC000;
   logic wr_ready, rd_valid, done;
   logic [DW-1:0] rd_data;
   logic [CNT_W-1:0] done_cnt;

   always #10 clk = ~clk;

   ata_pio_seq #(.CNT_W(CNT_W), .DATA_W(DW), .SECTOR_WORDS(256), .TMO_CYCLES(40),
                 .SPIN_CYCLES(400), .SETTLE_CYCLES(5), .DRIVE(1'b1)) dut_i (
      .clk, .rst_n, .start, .dir_wr, .lba_in, .count_in,
      .reg_req, .reg_we, .reg_addr, .reg_wdata, .reg_ack, .reg_rdata,
      .wr_valid, .wr_data, .wr_ready, .rd_valid, .rd_data, .done, .done_cnt);

   int checks = 0, errors = 0;

   // drive model state
   int n_acc, n_cmd, log_n, wr_seen, wr_bad, rd_served, rd_got, rd_bad, clr_reads;
   int busy_left, busy_k, err_after;
   bit busy_forever, last_data;
   logic [7:0] st_idle, sc_val;
   logic [2:0] log_a [64];
   logic [7:0] log_d [64];
   int res_cnt, res_cyc;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic chk_log(input int i, input logic [2:0] a, input logic [7:0] d, input string tag);
      chk(log_a[i] == a && log_d[i] == d, tag, {log_a[i], log_d[i]}, {a, d});
   endtask

   task automatic model_clear();
      n_acc = 0; n_cmd = 0; log_n = 0; wr_seen = 0; wr_bad = 0;
      rd_served = 0; rd_got = 0; rd_bad = 0; clr_reads = 0;
      busy_left = 0; busy_k = 0; err_after = 1000; busy_forever = 0; last_data = 0;
      st_idle = 8'h08; sc_val = 8'hFF;
   endtask

   always @(posedge clk) if (wr_valid && wr_ready) wr_data <= wr_data + 16'd1;

   always @(negedge clk) begin
      if (!rst_n) reg_ack = 1'b0;
      else if (reg_req && !reg_ack) begin
         reg_ack = 1'b1;
         n_acc++;
         if (reg_we) begin
            if (reg_addr == 3'd0) begin
               if (reg_wdata !== 16'(16'hC000 + wr_seen)) wr_bad++;
               wr_seen++; last_data = 1;
            end else begin
               if (log_n < 64) begin log_a[log_n] = reg_addr; log_d[log_n] = reg_wdata[7:0]; end
               log_n++; last_data = 0;
               if (reg_addr == 3'd7 && reg_wdata[7:0] != 8'hE5) begin n_cmd++; busy_left = busy_k; end
            end
         end else begin
            if (reg_addr == 3'd0) begin
               reg_rdata = 16'(16'hA000 + rd_served); rd_served++; last_data = 1;
            end else if (reg_addr == 3'd7) begin
               if (last_data) clr_reads++;
               last_data = 0;
               if (busy_forever) reg_rdata = 16'h0080;
               else if (busy_left > 0) begin reg_rdata = 16'h0080; busy_left--; end
               else if (n_cmd > err_after) reg_rdata = 16'h0009;
               else reg_rdata = {8'h00, st_idle};
            end else if (reg_addr == 3'd2) begin
               reg_rdata = {8'h00, sc_val}; last_data = 0;
            end else reg_rdata = '0;
         end
      end else reg_ack = 1'b0;
   end

   always @(negedge clk) if (rst_n && rd_valid) begin
      if (rd_data !== 16'(16'hA000 + rd_got)) rd_bad++;
      rd_got++;
   end

   task automatic run_req(input bit w, input logic [47:0] lba, input int cnt);
      @(negedge clk);
      wr_data = 16'hC000;
      dir_wr = w; lba_in = lba; count_in = CNT_W'(cnt); start = 1'b1;
      res_cyc = 0;
      @(negedge clk);
      start = 1'b0;
      res_cyc = 1;
      while (!done) begin @(negedge clk); res_cyc++; end
      res_cnt = int'(done_cnt);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!done && !reg_req && !wr_ready && !rd_valid, "R10 reset outputs idle",
          {done, reg_req, wr_ready, rd_valid}, 0);
   endtask

   task automatic t_zero();
      model_clear();
      run_req(1'b1, 48'h5, 0);
      chk(res_cnt == 0, "R1 zero count result", res_cnt, 0);
      chk(res_cyc == 1, "R1 done on next cycle", res_cyc, 1);
      chk(n_acc == 0, "R1 no register access", n_acc, 0);
   endtask

   task automatic t_write28();
      model_clear();
      run_req(1'b1, 48'h0000_0712_3456, 2);
      chk(res_cnt == 2, "R6 two sectors written", res_cnt, 2);
      chk(log_n == 13, "R4 taskfile write count", log_n, 13);
      chk_log(0, 3'd6, 8'h50, "R4 select");
      chk_log(1, 3'd2, 8'h01, "R4 count one");
      chk_log(2, 3'd3, 8'h56, "R4 low byte");
      chk_log(3, 3'd4, 8'h34, "R4 mid byte");
      chk_log(4, 3'd5, 8'h12, "R4 high byte");
      chk_log(5, 3'd6, 8'h57, "R4 device nibble");
      chk_log(6, 3'd7, 8'h30, "R4 write command");
      chk_log(8, 3'd3, 8'h57, "R6 address advanced");
      chk(wr_seen == 512 && wr_bad == 0, "R5 write words in order", wr_seen, 512);
      chk(clr_reads == 2, "R6 status read after data", clr_reads, 2);
   endtask

   task automatic t_read48();
      model_clear();
      run_req(1'b0, 48'h0012_3456_789A, 1);
      chk(res_cnt == 1, "R3 one sector read", res_cnt, 1);
      chk_log(1, 3'd7, 8'hE5, "R9 power query");
      chk_log(2, 3'd2, 8'h00, "R3 high pass count");
      chk_log(3, 3'd3, 8'h34, "R3 bits 31..24");
      chk_log(4, 3'd4, 8'h12, "R3 bits 39..32");
      chk_log(5, 3'd5, 8'h00, "R3 bits 47..40");
      chk_log(6, 3'd2, 8'h01, "R3 low pass count");
      chk_log(7, 3'd3, 8'h9A, "R3 bits 7..0");
      chk_log(10, 3'd6, 8'h50, "R3 device no nibble");
      chk_log(11, 3'd7, 8'h24, "R3 extended read");
      chk(rd_got == 256 && rd_bad == 0, "R5 read words in order", rd_got, 256);
   endtask

   task automatic t_mode_edge();
      model_clear();
      run_req(1'b1, 48'h0000_0FFF_FFFF, 1);
      chk(log_n == 7, "R2 28-bit at top of range", log_n, 7);
      chk_log(6, 3'd7, 8'h30, "R2 normal write command");
      model_clear();
      run_req(1'b1, 48'h0000_1000_0000, 1);
      chk(log_n == 11, "R2 48-bit at bit 28", log_n, 11);
      chk_log(10, 3'd7, 8'h34, "R2 extended write command");
   endtask

   task automatic t_busy();
      model_clear();
      busy_forever = 1;
      run_req(1'b1, 48'h100, 2);
      chk(res_cnt == 0, "R7 busy timeout count", res_cnt, 0);
      chk(n_cmd == 0, "R7 no command issued", n_cmd, 0);
   endtask

   task automatic t_err();
      model_clear();
      err_after = 1;
      run_req(1'b1, 48'h200, 3);
      chk(res_cnt == 1, "R8 stop at erroring sector", res_cnt, 1);
      chk(wr_seen == 256, "R8 no data after error", wr_seen, 256);
      model_clear();
      st_idle = 8'h00;
      run_req(1'b0, 48'h300, 2);
      chk(res_cnt == 0, "R8 missing DRQ stops", res_cnt, 0);
   endtask

   task automatic t_spin();
      model_clear();
      sc_val = 8'h00; busy_k = 50;
      run_req(1'b0, 48'h400, 1);
      chk(res_cnt == 1, "R9 standby uses long wait", res_cnt, 1);
      model_clear();
      sc_val = 8'hFF; busy_k = 50;
      run_req(1'b0, 48'h400, 1);
      chk(res_cnt == 0, "R9 active uses normal wait", res_cnt, 0);
   endtask

   task automatic t_restart();
      model_clear();
      @(negedge clk);
      dir_wr = 1'b1; lba_in = 48'h10; count_in = CNT_W'(1); start = 1'b1;
      @(negedge clk);
      count_in = CNT_W'(0);
      repeat (3) @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      chk(done_cnt == 1, "R10 start while busy ignored", int'(done_cnt), 1);
      @(negedge clk);
   endtask

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_zero();
      t_write28();
      t_read48();
      t_mode_edge();
      t_busy();
      t_err();
      t_spin();
      t_restart();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule